// File: doc/BRIEF.md
# PRBS Pair Checker

This block is a receive-side test-pattern monitor for a T1/E1 line interface. It takes one received bit on each clock that has the bit enable set. Without any start command, it keeps searching the stream for the test pattern chosen by a select pin. The first pattern is a 2^15-1 pseudo-random sequence. The second is a zero-limited quasi-random signal source (QRSS) built on a 2^20-1 sequence.

While it searches, the checker copies the received bits into its history register and predicts each next bit from them. After enough correct predictions in a row it declares lock. From then on it builds its own reference from its own predictions, so one line error shows up as exactly one errored bit. A single status pin reports both results: it stays high while the checker is out of sync and drops low once it is locked. After lock it rises for one bit period on each errored bit. If errors come too densely, the checker falls back to searching. A saturating counter of errored bits is also brought out.

The controller has three states:
- ST_HUNT: no matching run in progress.
- ST_TRACK: a run of correct predictions is being counted.
- ST_LOCK: synchronised.

Its transitions are:
- HUNT→TRACK on the first valid match.
- TRACK→HUNT on any mismatch or invalid history.
- TRACK→LOCK on the 32nd consecutive match.
- LOCK→HUNT when the error window trips.
- Any state → HUNT on a pattern-select change or on synchronous reset.

Top module: `prbs_pair_checker`

## Requirements
- R1: With `srst` high at a clock edge, the following values appear after that edge: `err_stat`=1, `locked`=0 and `err_cnt`=0. The history register is also cleared to all zeros.
- R2: The checker always searches for the selected pattern. A clean stream of that pattern reaches lock, with `err_stat` low, within 150 enabled bits. It relocks in the same way after losing lock.
- R3: While `locked` is 0, `err_stat` is 1.
- R4: Lock is declared on the 32nd consecutive matching prediction. A match counts only if the history is valid, and a mismatch or an invalid history restarts the count. History is valid when the newest 15 received bits (for `pat_sel`=0) or the newest 20 received bits (for `pat_sel`=1) are neither all zeros nor all ones. As a result, an all-zero or all-one stream never locks.
- R5: For `pat_sel`=0, each predicted bit is b[t] = b[t-15] XOR b[t-14], which is the x^15+x^14+1 sequence.
- R6: For `pat_sel`=1, the raw sequence r follows r[t] = r[t-20] XOR r[t-17], which is the x^20+x^17+1 sequence. The transmitted bit is r[t], forced to 1 whenever r[t+1] to r[t+14] are all zero.
- R7: While locked, `err_stat` is updated once per enabled bit. It is set to 1 for that bit if the received bit differs from the reference, and to 0 otherwise. The reference advances on its own predictions, so one flipped bit gives exactly one pulse.
- R8: Lock is lost, and `err_stat` returns high, on the enabled bit that makes the error count over the last 64 enabled bits reach 6. Five errors within 64 bits keep lock.
- R9: A change of `pat_sel` sends the checker to ST_HUNT with `err_stat`=1 at the next edge. The bit presented in that cycle is ignored.
- R10: `err_cnt` counts errored bits while locked and saturates at 2^CNT_W-1. It is cleared when lock is acquired and is kept when lock is lost.
- R11: Cycles with `bit_en` low change neither `err_stat`, `err_cnt` nor the lock state, whatever `rx_bit` does.
- R12: A synchronous reset during lock returns the block to the R1 state at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Marks a cycle that carries a received bit |
| rx_bit | input | 1 | Received serial data |
| pat_sel | input | 1 | 0 selects the 2^15-1 pattern, 1 selects QRSS |
| err_stat | output | 1 | High when out of sync; one-bit pulse per error when locked |
| locked | output | 1 | High in the synchronised state |
| err_cnt | output | CNT_W | Saturating count of errored bits since lock was acquired |

## Verification
The bench seeds the QRSS generator so that its forced-one region (the 19-zero raw run) passes while the checker is locked. A checker that predicts the zero-limit rule wrongly would log errors there, or lose lock, on a clean stream. Two error bursts are injected: five errors spread over 50 bits, then six errors within 30 bits. These expose a window that trips one error early or one error late. All-zero and all-one streams are fed to catch a checker that locks on a stuck line. The run also covers pattern switching, gaps in `bit_en`, and counter saturation, which expose outputs that move on idle cycles and a counter that wraps instead of holding.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_TRACK = 2'd1,
        ST_LOCK  = 2'd2
    } chk_state_t;

    // Short pattern: x^15 + x^14 + 1
    localparam int P15_LEN   = 15;
    localparam int P15_TAP   = 14;
    // Long pattern: x^20 + x^17 + 1 with zero limiting
    localparam int QRSS_LEN  = 20;
    localparam int QRSS_TAP  = 17;
    localparam int QRSS_ZRUN = 14;

    localparam int HIST_W    = QRSS_LEN;

endpackage

// File: rtl/prbs_predict.sv
module prbs_predict
    import prbs_chk_pkg::*;
(
    input  logic clk,
    input  logic srst,
    input  logic shift_en,
    input  logic shift_bit,
    input  logic pat_qrss,
    output logic pred_out,
    output logic pred_raw,
    output logic hist_ok
);

    // hist[0] is the newest bit, hist[k] is k bits older
    logic [HIST_W-1:0]  hist;
    logic [QRSS_ZRUN:0] ahead;
    logic               p15_bit;
    logic               q_zero;
    logic               q_out;

    always_ff @(posedge clk) begin
        if (srst) begin
            hist <= '0;
        end else if (shift_en) begin
            hist <= {hist[HIST_W-2:0], shift_bit};
        end
    end

    assign p15_bit = hist[P15_LEN-1] ^ hist[P15_TAP-1];

    // Raw bits t..t+14 all follow directly from the stored history
    for (genvar k = 0; k <= QRSS_ZRUN; k++) begin : g_ahead
        assign ahead[k] = hist[QRSS_LEN-1-k] ^ hist[QRSS_TAP-1-k];
    end

    assign q_zero = ~|ahead[QRSS_ZRUN:1];
    assign q_out  = ahead[0] | q_zero;

    always_comb begin
        if (pat_qrss) begin
            pred_raw = ahead[0];
            pred_out = q_out;
            hist_ok  = (hist != '0) && (hist != '1);
        end else begin
            pred_raw = p15_bit;
            pred_out = p15_bit;
            hist_ok  = (hist[P15_LEN-1:0] != '0) && (hist[P15_LEN-1:0] != '1);
        end
    end

endmodule

// File: rtl/prbs_err_window.sv
module prbs_err_window #(
    parameter int WIN_LEN = 64,
    parameter int WIN_LIM = 6
) (
    input  logic clk,
    input  logic clr,
    input  logic push,
    input  logic err_in,
    output logic trip
);

    localparam int CW = $clog2(WIN_LEN + 1);

    logic [WIN_LEN-1:0] win;
    logic [CW-1:0]      cnt;
    logic [CW-1:0]      nxt;

    assign nxt  = cnt + CW'(err_in) - CW'(win[WIN_LEN-1]);
    assign trip = push && (nxt >= CW'(WIN_LIM));

    always_ff @(posedge clk) begin
        if (clr) begin
            win <= '0;
            cnt <= '0;
        end else if (push) begin
            win <= {win[WIN_LEN-2:0], err_in};
            cnt <= nxt;
        end
    end

    AST_WIN_CAP: assert property (@(posedge clk) disable iff (clr)
        cnt <= CW'(WIN_LIM)); // R8

endmodule

// File: rtl/prbs_pair_checker.sv
module prbs_pair_checker
    import prbs_chk_pkg::*;
#(
    parameter int LOCK_RUN = 32,
    parameter int WIN_LEN  = 64,
    parameter int WIN_LIM  = 6,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             bit_en,
    input  logic             rx_bit,
    input  logic             pat_sel,
    output logic             err_stat,
    output logic             locked,
    output logic [CNT_W-1:0] err_cnt
);

    localparam int               RUN_W   = $clog2(LOCK_RUN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    chk_state_t       state, state_d;
    logic [RUN_W-1:0] run_q, run_d;
    logic             pat_q;
    logic             err_q;
    logic [CNT_W-1:0] cnt_q;

    logic pat_chg;
    logic pred_out, pred_raw, hist_ok;
    logic match, hit, hunting;
    logic shift_en, shift_bit;
    logic win_clr, win_push, trip;

    assign pat_chg   = (pat_sel != pat_q);
    assign hunting   = (state != ST_LOCK);
    assign match     = (rx_bit == pred_out);
    assign hit       = match && hist_ok;
    assign shift_en  = bit_en && !pat_chg;
    assign shift_bit = hunting ? rx_bit : pred_raw;
    assign win_clr   = srst || hunting || pat_chg;
    assign win_push  = bit_en && !hunting;

    prbs_predict u_predict (
        .clk       (clk),
        .srst      (srst),
        .shift_en  (shift_en),
        .shift_bit (shift_bit),
        .pat_qrss  (pat_q),
        .pred_out  (pred_out),
        .pred_raw  (pred_raw),
        .hist_ok   (hist_ok)
    );

    prbs_err_window #(
        .WIN_LEN (WIN_LEN),
        .WIN_LIM (WIN_LIM)
    ) u_window (
        .clk    (clk),
        .clr    (win_clr),
        .push   (win_push),
        .err_in (!match),
        .trip   (trip)
    );

    // Next-state logic
    always_comb begin
        state_d = state;
        run_d   = run_q;
        unique case (state)
            ST_HUNT: begin
                if (bit_en && hit) begin
                    state_d = ST_TRACK;
                    run_d   = RUN_W'(1);
                end
            end
            ST_TRACK: begin
                if (bit_en) begin
                    if (hit) begin
                        if (run_q == RUN_W'(LOCK_RUN - 1)) begin
                            state_d = ST_LOCK;
                            run_d   = '0;
                        end else begin
                            run_d = run_q + RUN_W'(1);
                        end
                    end else begin
                        state_d = ST_HUNT;
                        run_d   = '0;
                    end
                end
            end
            ST_LOCK: begin
                if (bit_en && trip) begin
                    state_d = ST_HUNT;
                    run_d   = '0;
                end
            end
            default: begin
                state_d = ST_HUNT;
                run_d   = '0;
            end
        endcase
        if (pat_chg) begin
            state_d = ST_HUNT;
            run_d   = '0;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (srst) begin
            state <= ST_HUNT;
            run_q <= '0;
        end else begin
            state <= state_d;
            run_q <= run_d;
        end
    end

    // Output and counter register
    always_ff @(posedge clk) begin
        if (srst) begin
            err_q <= 1'b1;
            cnt_q <= '0;
            pat_q <= pat_sel;
        end else begin
            pat_q <= pat_sel;
            if (pat_chg) begin
                err_q <= 1'b1;
            end else if (bit_en) begin
                err_q <= (state_d != ST_LOCK) ? 1'b1 : (hunting ? 1'b0 : !match);
            end
            if (state_d == ST_LOCK && hunting) begin
                cnt_q <= '0;
            end else if (!hunting && bit_en && !pat_chg && !match && cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign err_stat = err_q;
    assign locked   = (state == ST_LOCK);
    assign err_cnt  = cnt_q;

    AST_HUNT_FLAG: assert property (@(posedge clk) disable iff (srst)
        (state != ST_LOCK) |-> err_q); // R3

    AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (srst)
        (state == ST_LOCK && $past(state) != ST_LOCK) |-> ($past(state) == ST_TRACK)); // R4

    AST_SEL_RESYNC: assert property (@(posedge clk) disable iff (srst)
        pat_chg |=> (state == ST_HUNT && err_q)); // R9

    AST_CNT_FRESH: assert property (@(posedge clk) disable iff (srst)
        (state == ST_LOCK && $past(state) != ST_LOCK) |-> (cnt_q == '0)); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (srst)
        (state == ST_LOCK && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (srst)
        (!bit_en && !pat_chg) |=> ($stable(err_q) && $stable(cnt_q) && $stable(state))); // R11

endmodule

// File: tb/prbs_pair_checker_tb.sv
`timescale 1ns/1ps
module prbs_pair_checker_tb_top;

    localparam int CNT_W = 6;
    localparam int M_MAX = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             srst = 1'b1;
    logic             bit_en = 1'b0;
    logic             rx_bit = 1'b0;
    logic             pat_sel = 1'b0;
    logic             err_stat;
    logic             locked;
    logic [CNT_W-1:0] err_cnt;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    prbs_pair_checker #(.CNT_W(CNT_W)) dut_i (
        .clk      (clk),
        .srst     (srst),
        .bit_en   (bit_en),
        .rx_bit   (rx_bit),
        .pat_sel  (pat_sel),
        .err_stat (err_stat),
        .locked   (locked),
        .err_cnt  (err_cnt)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit mh[$];
    bit mw[$];
    int m_state;
    int m_run;
    bit m_err;
    int m_cnt;
    bit m_pat;
    bit ready = 1'b0;

    function automatic void m_predict(output bit po, output bit pr, output bit ok);
        int len;
        int ones;
        bit ah[15];
        bit z;
        len = m_pat ? 20 : 15;
        ones = 0;
        for (int i = 0; i < len; i++) ones += mh[i];
        ok = (ones != 0) && (ones != len);
        if (!m_pat) begin
            pr = mh[14] ^ mh[13];
            po = pr;
        end else begin
            for (int k = 0; k < 15; k++) ah[k] = mh[19 - k] ^ mh[16 - k];
            z = 1'b1;
            for (int k = 1; k < 15; k++) if (ah[k]) z = 1'b0;
            pr = ah[0];
            po = ah[0] | z;
        end
    endfunction

    task automatic m_bit(bit rx);
        bit po, pr, ok, e;
        int sum;
        m_predict(po, pr, ok);
        if (m_state != 2) begin
            mh.push_front(rx);
            void'(mh.pop_back());
            if (rx == po && ok) begin
                m_run++;
                if (m_run == 32) begin
                    m_state = 2; m_run = 0; mw = {}; m_cnt = 0; m_err = 1'b0;
                end else begin
                    m_state = 1; m_err = 1'b1;
                end
            end else begin
                m_run = 0; m_state = 0; m_err = 1'b1;
            end
        end else begin
            mh.push_front(pr);
            void'(mh.pop_back());
            e = (rx != po);
            mw.push_back(e);
            if (mw.size() > 64) void'(mw.pop_front());
            if (e && m_cnt < M_MAX) m_cnt++;
            sum = 0;
            foreach (mw[i]) sum += mw[i];
            if (sum >= 6) begin
                m_state = 0; m_run = 0; mw = {}; m_err = 1'b1;
            end else begin
                m_err = e;
            end
        end
    endtask

    always @(posedge clk) begin
        if (srst) begin
            mh = {};
            repeat (20) mh.push_back(1'b0);
            mw = {}; m_state = 0; m_run = 0; m_err = 1'b1; m_cnt = 0;
            m_pat = pat_sel; ready = 1'b1;
        end else if (pat_sel != m_pat) begin
            m_pat = pat_sel; m_state = 0; m_run = 0; mw = {}; m_err = 1'b1;
        end else if (bit_en) begin
            m_bit(rx_bit);
        end
    end

    always @(negedge clk) begin
        if (ready) begin
            chk("R3 R7 err_stat vs model", int'(err_stat), int'(m_err));
            chk("R4 R8 locked vs model", int'(locked), int'(m_state == 2));
            chk("R10 err_cnt vs model", int'(err_cnt), m_cnt);
        end
    end

    // ---------------- stimulus sources ----------------
    logic [14:0] g15 = 15'h0001;
    logic [19:0] gq;
    bit          fq[$];

    task automatic next_p15(output bit b);
        b = g15[14] ^ g15[13];
        g15 = {g15[13:0], b};
    endtask

    task automatic next_q(output bit b);
        bit nb;
        bit z;
        while (fq.size() < 15) begin
            nb = gq[19] ^ gq[16];
            gq = {gq[18:0], nb};
            fq.push_back(nb);
        end
        z = 1'b1;
        for (int k = 1; k < 15; k++) if (fq[k]) z = 1'b0;
        b = fq[0] | z;
        void'(fq.pop_front());
    endtask

    task automatic send(bit b, bit en);
        @(negedge clk);
        bit_en = en;
        rx_bit = b;
    endtask

    task automatic look();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        srst = 1'b1; bit_en = 1'b0;
        repeat (2) @(negedge clk);
        srst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit b;
        // QRSS seed placed 300 raw bits before the longest zero run
        gq = 20'h80000;
        for (int i = 0; i < 300; i++) gq = {gq[0] ^ gq[17], gq[19:1]};

        do_reset();
        look();
        chk("R1 reset err_stat", int'(err_stat), 1);
        chk("R1 reset locked", int'(locked), 0);
        chk("R1 reset err_cnt", int'(err_cnt), 0);

        for (int i = 0; i < 150; i++) begin next_p15(b); send(b, 1'b1); end
        look();
        chk("R2 R5 lock on 2^15-1", int'(locked), 1);
        chk("R2 err_stat low after lock", int'(err_stat), 0);
        chk("R5 clean count", int'(err_cnt), 0);

        next_p15(b); send(~b, 1'b1);
        look();
        chk("R7 pulse on flipped bit", int'(err_stat), 1);
        next_p15(b); send(b, 1'b1);
        look();
        chk("R7 pulse ends after one bit", int'(err_stat), 0);
        chk("R7 single error counted once", int'(err_cnt), 1);

        for (int i = 0; i < 60; i++) begin next_p15(b); send(b, 1'b1); end
        for (int i = 0; i < 50; i++) begin
            next_p15(b);
            if (i % 10 == 9) b = ~b;
            send(b, 1'b1);
        end
        look();
        chk("R8 five errors keep lock", int'(locked), 1);
        chk("R8 count after five", int'(err_cnt), 6);

        for (int i = 0; i < 100; i++) begin next_p15(b); send(b, 1'b1); end
        for (int i = 0; i < 30; i++) begin
            next_p15(b);
            if (i % 5 == 4) b = ~b;
            send(b, 1'b1);
        end
        look();
        chk("R8 six errors drop lock", int'(locked), 0);
        chk("R3 status high after loss", int'(err_stat), 1);
        chk("R10 count kept on loss", int'(err_cnt), 12);

        for (int i = 0; i < 120; i++) begin next_p15(b); send(b, 1'b1); end
        look();
        chk("R2 relock", int'(locked), 1);
        chk("R10 count cleared on relock", int'(err_cnt), 0);

        for (int i = 0; i < 10; i++) send(bit'($urandom() % 2), 1'b0);
        look();
        chk("R11 idle keeps status", int'(err_stat), 0);
        chk("R11 idle keeps count", int'(err_cnt), 0);
        chk("R11 idle keeps lock", int'(locked), 1);

        @(negedge clk); pat_sel = 1'b1; bit_en = 1'b0;
        look();
        chk("R9 select change unlocks", int'(locked), 0);
        chk("R9 select change raises status", int'(err_stat), 1);

        for (int i = 0; i < 1050; i++) begin
            if (i % 3 != 2) begin next_q(b); send(b, 1'b1); end
            else send(bit'($urandom() % 2), 1'b0);
        end
        look();
        chk("R6 lock on QRSS through forced ones", int'(locked), 1);
        chk("R6 R11 QRSS clean count", int'(err_cnt), 0);

        @(negedge clk); srst = 1'b1; bit_en = 1'b0;
        look();
        chk("R12 reset drops lock", int'(locked), 0);
        chk("R12 reset raises status", int'(err_stat), 1);
        chk("R12 reset clears count", int'(err_cnt), 0);
        @(negedge clk); srst = 1'b0;

        for (int i = 0; i < 300; i++) send(1'b1, 1'b1);
        look();
        chk("R4 all ones never lock QRSS", int'(locked), 0);

        @(negedge clk); pat_sel = 1'b0;
        do_reset();
        for (int i = 0; i < 300; i++) send(1'b0, 1'b1);
        look();
        chk("R4 all zeros never lock", int'(locked), 0);

        do_reset();
        for (int i = 0; i < 150; i++) begin next_p15(b); send(b, 1'b1); end
        for (int i = 0; i < 1280; i++) begin
            next_p15(b);
            if (i % 16 == 15) b = ~b;
            send(b, 1'b1);
        end
        look();
        chk("R10 counter saturates", int'(err_cnt), M_MAX);
        chk("R10 lock held under sparse errors", int'(locked), 1);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule